// File: doc/BRIEF.md
# Multi-Cycle RISC Execution Sequencer

This block is a small non-pipelined processor core for a subset of a 32-bit instruction set with three formats. Each instruction walks through a fixed set of named states: fetch, decode/register read, execute/address, memory/branch completion and write-back. Between states, the intermediate values are held in internal registers: the fetched instruction, the next PC, operands A and B, the sign-extended immediate, the ALU result, the branch condition and the loaded data. Each instruction class leaves the walk as soon as its work is done, so an instruction takes between two and five cycles.

The core reaches instruction and data through a single word-addressed memory port. The memory is expected to return read data combinationally for the address the core presents, and to write on the clock edge when write enable is high. A debug port shows the current PC and one register of the register file. The debug register is picked by an index.

Top module: `mc_core`

## Requirements
- R1: While rst_ni is low, the PC, the memory address and the write enable are all 0, and every register reads as 0. The first instruction is fetched from word 0.
- R2: A word with opcode 0 (bits 31:26) is register-register. rs is bits 25:21, rt is bits 20:16, rd is bits 15:11 and shamt is bits 10:6. The operation comes from funct (bits 5:0): 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than, 0x00 shift rt left by shamt, 0x02 shift rt right logically by shamt. The result goes to rd and the instruction takes 4 cycles.
- R3: The register-immediate opcodes are 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or and 0x0E xor. Each combines rs with bits 15:0 sign-extended to 32 bits, writes rt, and takes 4 cycles.
- R4: Opcode 0x0F writes {imm, 16'h0} to rt and takes 4 cycles.
- R5: Opcode 0x23 (load) reads the word at byte address rs+sext(imm) and writes it to rt. It takes 5 cycles.
- R6: Opcode 0x2B (store) writes rt to byte address rs+sext(imm) and takes 4 cycles. Write enable is high only in the memory state, and no other word is touched.
- R7: Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. The target is PC+4+sext(imm), with the immediate used as a byte offset. Both take 4 cycles.
- R8: Opcode 0x02 (jump) sets the PC to {PC[31:28], bits 25:0, 2'b00} and takes 2 cycles.
- R9: Register 0 always reads as 0, and writes to it have no effect.
- R10: An instruction that does not redirect the PC leaves the PC at PC+4. An unknown opcode or funct acts as a 2-cycle no-op.
- R11: dbg_pc_o shows the PC. dbg_reg_data_o shows the register chosen by dbg_reg_sel_i, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | ADDR_W | Word address for the memory port |
| mem_wdata_o | output | 32 | Store data |
| mem_we_o | output | 1 | Write enable for the memory port |
| mem_rdata_i | input | 32 | Read data returned for mem_addr_o |
| dbg_pc_o | output | 32 | Current PC |
| dbg_reg_sel_i | input | 5 | Debug register index |
| dbg_reg_data_o | output | 32 | Value of the selected register |

## Verification
Some properties are checked by assertions on every cycle:
- memory writes happen only in the memory state;
- the PC changes only at the boundary of an instruction;
- in decode, the next-PC register holds PC+4;
- write-back is entered only from execute or memory;
- the debug read of register 0 is always zero.

Other behaviour is shown only by the bench's program runs:
- the arithmetic result of each operation over a sweep of operand pairs, immediates and shift amounts;
- the taken and not-taken paths of both branch types;
- the jump target;
- the exact cycle count of each instruction mix.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB
  } state_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_SLL, ALU_SRL, ALU_LUI
  } alu_op_e;

  typedef enum logic [2:0] {
    CL_ALU_R, CL_ALU_I, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP, CL_NONE
  } iclass_e;

  typedef struct packed {
    iclass_e cls;
    alu_op_e op;
    logic    use_imm;
    logic    br_ne;
  } dec_t;
endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o.cls     = CL_NONE;
    dec_o.op      = ALU_ADD;
    dec_o.use_imm = 1'b1;
    dec_o.br_ne   = 1'b0;
    unique case (opcode_i)
      OP_RTYPE: begin
        dec_o.cls     = CL_ALU_R;
        dec_o.use_imm = 1'b0;
        unique case (funct_i)
          FN_ADD:  dec_o.op = ALU_ADD;
          FN_SUB:  dec_o.op = ALU_SUB;
          FN_AND:  dec_o.op = ALU_AND;
          FN_OR:   dec_o.op = ALU_OR;
          FN_XOR:  dec_o.op = ALU_XOR;
          FN_SLT:  dec_o.op = ALU_SLT;
          FN_SLL:  dec_o.op = ALU_SLL;
          FN_SRL:  dec_o.op = ALU_SRL;
          default: dec_o.cls = CL_NONE;
        endcase
      end
      OP_ADDI: begin dec_o.cls = CL_ALU_I; dec_o.op = ALU_ADD; end
      OP_SLTI: begin dec_o.cls = CL_ALU_I; dec_o.op = ALU_SLT; end
      OP_ANDI: begin dec_o.cls = CL_ALU_I; dec_o.op = ALU_AND; end
      OP_ORI:  begin dec_o.cls = CL_ALU_I; dec_o.op = ALU_OR;  end
      OP_XORI: begin dec_o.cls = CL_ALU_I; dec_o.op = ALU_XOR; end
      OP_LUI:  begin dec_o.cls = CL_ALU_I; dec_o.op = ALU_LUI; end
      OP_LW:   dec_o.cls = CL_LOAD;
      OP_SW:   dec_o.cls = CL_STORE;
      OP_BEQ:  dec_o.cls = CL_BRANCH;
      OP_BNE:  begin dec_o.cls = CL_BRANCH; dec_o.br_ne = 1'b1; end
      OP_J:    dec_o.cls = CL_JUMP;
      default: dec_o.cls = CL_NONE;
    endcase
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e                  op_i,
  input  logic [W-1:0]             x_i,
  input  logic [W-1:0]             y_i,
  input  logic [$clog2(W)-1:0]     shamt_i,
  output logic [W-1:0]             y_o
);
  localparam int HALF = W / 2;

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = x_i + y_i;
      ALU_SUB: y_o = x_i - y_i;
      ALU_AND: y_o = x_i & y_i;
      ALU_OR:  y_o = x_i | y_i;
      ALU_XOR: y_o = x_i ^ y_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, $signed(x_i) < $signed(y_i)};
      ALU_SLL: y_o = y_i << shamt_i;
      ALU_SRL: y_o = y_i >> shamt_i;
      ALU_LUI: y_o = {y_i[HALF-1:0], {HALF{1'b0}}};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XW  = 32,
  parameter int AW  = 5,
  parameter int NRD = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [XW-1:0]            wdata_i,
  input  logic [NRD-1:0][AW-1:0]   raddr_i,
  output logic [NRD-1:0][XW-1:0]   rdata_o
);
  localparam int NREG = 2 ** AW;

  logic [XW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : regs_q[raddr_i[p]];
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  iclass_e cls_i,
  output state_e  state_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = (cls_i == CL_JUMP || cls_i == CL_NONE) ? ST_FETCH : ST_EXEC;
      ST_EXEC:   state_d = (cls_i == CL_LOAD || cls_i == CL_STORE || cls_i == CL_BRANCH)
                           ? ST_MEM : ST_WB;
      ST_MEM:    state_d = (cls_i == CL_LOAD) ? ST_WB : ST_FETCH;
      ST_WB:     state_d = ST_FETCH;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic              mem_we_o,
  input  logic [31:0]       mem_rdata_i,
  output logic [31:0]       dbg_pc_o,
  input  logic [4:0]        dbg_reg_sel_i,
  output logic [31:0]       dbg_reg_data_o
);
  localparam int NRD    = 3;
  localparam int SH_W   = $clog2(XLEN);
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;

  logic [XLEN-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_q, lmd_q;
  logic            cond_q;
  state_e          state;
  dec_t            dec;

  logic [REG_AW-1:0] f_rs, f_rt, f_rd;
  logic [SH_W-1:0]   f_sh;
  assign f_rs = ir_q[25:21];
  assign f_rt = ir_q[20:16];
  assign f_rd = ir_q[15:11];
  assign f_sh = ir_q[10:6];

  mc_decode u_dec (
    .opcode_i (ir_q[31:26]),
    .funct_i  (ir_q[5:0]),
    .dec_o    (dec)
  );

  mc_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cls_i   (dec.cls),
    .state_o (state)
  );

  logic [NRD-1:0][REG_AW-1:0] rf_raddr;
  logic [NRD-1:0][XLEN-1:0]   rf_rdata;
  logic                       rf_we;
  logic [REG_AW-1:0]          rf_waddr;
  logic [XLEN-1:0]            rf_wdata;

  assign rf_raddr[0] = f_rs;
  assign rf_raddr[1] = f_rt;
  assign rf_raddr[2] = dbg_reg_sel_i;
  assign rf_we       = (state == ST_WB);
  assign rf_waddr    = (dec.cls == CL_ALU_R) ? f_rd : f_rt;
  assign rf_wdata    = (dec.cls == CL_LOAD) ? lmd_q : alu_q;

  mc_regfile #(.XW(XLEN), .AW(REG_AW), .NRD(NRD)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  logic [XLEN-1:0] alu_x, alu_yin, alu_y;
  assign alu_x   = (dec.cls == CL_BRANCH) ? npc_q : a_q;
  assign alu_yin = dec.use_imm ? imm_q : b_q;

  mc_alu #(.W(XLEN)) u_alu (
    .op_i    (dec.op),
    .x_i     (alu_x),
    .y_i     (alu_yin),
    .shamt_i (f_sh),
    .y_o     (alu_y)
  );

  logic [XLEN-1:0] jump_tgt;
  assign jump_tgt = {pc_q[XLEN-1:TGT_W+2], ir_q[TGT_W-1:0], 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= RESET_PC;
      npc_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      imm_q  <= '0;
      alu_q  <= '0;
      lmd_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH: begin
          ir_q  <= mem_rdata_i;
          npc_q <= pc_q + 32'd4;
        end
        ST_DECODE: begin
          a_q   <= rf_rdata[0];
          b_q   <= rf_rdata[1];
          imm_q <= {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
          if (dec.cls == CL_JUMP)      pc_q <= jump_tgt;
          else if (dec.cls == CL_NONE) pc_q <= npc_q;
        end
        ST_EXEC: begin
          alu_q  <= alu_y;
          cond_q <= dec.br_ne ? (a_q != b_q) : (a_q == b_q);
        end
        ST_MEM: begin
          if (dec.cls == CL_LOAD)   lmd_q <= mem_rdata_i;
          if (dec.cls == CL_BRANCH) pc_q  <= cond_q ? alu_q : npc_q;
          if (dec.cls == CL_STORE)  pc_q  <= npc_q;
        end
        ST_WB: pc_q <= npc_q;
        default: ;
      endcase
    end
  end

  // one shared port: fetch uses PC, memory state uses the computed address
  assign mem_addr_o     = (state == ST_FETCH) ? pc_q[ADDR_W+1:2] : alu_q[ADDR_W+1:2];
  assign mem_wdata_o    = b_q;
  assign mem_we_o       = (state == ST_MEM) && (dec.cls == CL_STORE);
  assign dbg_pc_o       = pc_q;
  assign dbg_reg_data_o = rf_rdata[2];
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input state_e      state_i,
  input logic [31:0] pc_i,
  input logic [31:0] npc_i,
  input logic        mem_we_i,
  input logic [4:0]  dbg_sel_i,
  input logic [31:0] dbg_data_i
);
  AST_WE_IN_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> state_i == ST_MEM); // R6

  AST_PC_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_i) |-> state_i == ST_FETCH); // R10

  AST_NPC_PLUS4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_DECODE |-> npc_i == pc_i + 32'd4); // R10

  AST_WB_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_WB |-> ($past(state_i) == ST_EXEC || $past(state_i) == ST_MEM)); // R2

  AST_R0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_sel_i == 5'd0 |-> dbg_data_i == 32'd0); // R9
endmodule

bind mc_core mc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_i    (state),
  .pc_i       (pc_q),
  .npc_i      (npc_q),
  .mem_we_i   (mem_we_o),
  .dbg_sel_i  (dbg_reg_sel_i),
  .dbg_data_i (dbg_reg_data_o)
);

// File: tb/mc_core_test.sv
module mc_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata, dbg_pc, dbg_data;
  logic          mem_we;
  logic [4:0]    dbg_sel = 5'd0;
  logic [31:0]   mem [0:(1<<AW)-1];

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_core #(.ADDR_W(AW)) uut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .mem_addr_o     (mem_addr),
    .mem_wdata_o    (mem_wdata),
    .mem_we_o       (mem_we),
    .mem_rdata_i    (mem_rdata),
    .dbg_pc_o       (dbg_pc),
    .dbg_reg_sel_i  (dbg_sel),
    .dbg_reg_data_o (dbg_data)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  function automatic logic [31:0] val(int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h1234_5678;
      6: return 32'hFEDC_BA98;
      default: return 32'h0000_FFFF;
    endcase
  endfunction

  task automatic rd_reg(input int idx, output logic [31:0] v);
    dbg_sel = 5'(idx);
    #1;
    v = dbg_data;
  endtask

  task automatic clear_mem();
    for (int k = 0; k < (1 << AW); k++) mem[k] <= 32'h0;
  endtask

  // reset, then count edges until PC reaches halt_pc
  task automatic run(input logic [31:0] halt_pc, output int cycles);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", dbg_pc, 32'h0);
    chk("R1", "addr in reset", 32'(mem_addr), 32'h0);
    chk("R1", "we in reset", 32'(mem_we), 32'h0);
    rst_ni = 1'b1;
    cycles = 0;
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk);
      #1;
      cycles++;
      if (dbg_pc == halt_pc) break;
    end
    @(negedge clk);
  endtask

  task automatic alu_case(input logic [31:0] x, input logic [31:0] y, input logic [15:0] imm, input int sh);
    logic [31:0] se, v;
    int cyc;
    se = {{16{imm[15]}}, imm};
    clear_mem();
    mem[0]  <= enc_i(6'h23, 0, 1, 16'h0800);
    mem[1]  <= enc_i(6'h23, 0, 2, 16'h0804);
    mem[2]  <= enc_r(1, 2, 3, 0, 6'h20);
    mem[3]  <= enc_r(1, 2, 4, 0, 6'h22);
    mem[4]  <= enc_r(1, 2, 5, 0, 6'h24);
    mem[5]  <= enc_r(1, 2, 6, 0, 6'h25);
    mem[6]  <= enc_r(1, 2, 7, 0, 6'h26);
    mem[7]  <= enc_r(1, 2, 8, 0, 6'h2A);
    mem[8]  <= enc_r(0, 2, 9, sh, 6'h00);
    mem[9]  <= enc_r(0, 2, 10, sh, 6'h02);
    mem[10] <= enc_i(6'h08, 1, 11, imm);
    mem[11] <= enc_i(6'h0A, 1, 12, imm);
    mem[12] <= enc_i(6'h0C, 1, 13, imm);
    mem[13] <= enc_i(6'h0D, 1, 14, imm);
    mem[14] <= enc_i(6'h0E, 1, 15, imm);
    mem[15] <= enc_i(6'h0F, 0, 16, imm);
    mem[16] <= enc_i(6'h2B, 0, 3, 16'h0808);
    mem[17] <= enc_j(26'd17);
    mem[512] <= x;
    mem[513] <= y;
    mem[515] <= 32'hA5A5_5A5A;
    run(32'd68, cyc);
    chk("R5", "load/alu/store cycle total", 32'(cyc), 32'd70);
    rd_reg(1, v);  chk("R5", "load r1", v, x);
    rd_reg(2, v);  chk("R5", "load r2", v, y);
    rd_reg(3, v);  chk("R2", "add", v, x + y);
    rd_reg(4, v);  chk("R2", "sub", v, x - y);
    rd_reg(5, v);  chk("R2", "and", v, x & y);
    rd_reg(6, v);  chk("R2", "or", v, x | y);
    rd_reg(7, v);  chk("R2", "xor", v, x ^ y);
    rd_reg(8, v);  chk("R2", "slt", v, ($signed(x) < $signed(y)) ? 32'd1 : 32'd0);
    rd_reg(9, v);  chk("R2", "sll", v, y << sh);
    rd_reg(10, v); chk("R2", "srl", v, y >> sh);
    rd_reg(11, v); chk("R3", "addi", v, x + se);
    rd_reg(12, v); chk("R3", "slti", v, ($signed(x) < $signed(se)) ? 32'd1 : 32'd0);
    rd_reg(13, v); chk("R3", "andi", v, x & se);
    rd_reg(14, v); chk("R3", "ori", v, x | se);
    rd_reg(15, v); chk("R3", "xori", v, x ^ se);
    rd_reg(16, v); chk("R4", "lui", v, {imm, 16'h0});
    chk("R6", "stored word", mem[514], x + y);
    chk("R6", "neighbour untouched", mem[515], 32'hA5A5_5A5A);
    chk("R11", "halt pc", dbg_pc, 32'd68);
  endtask

  task automatic branch_case(input logic [31:0] x, input logic [31:0] y);
    logic [31:0] v;
    int cyc;
    logic eq;
    eq = (x == y);
    clear_mem();
    mem[0]  <= enc_i(6'h23, 0, 1, 16'h0800);
    mem[1]  <= enc_i(6'h23, 0, 2, 16'h0804);
    mem[2]  <= enc_i(6'h04, 1, 2, 16'd8);
    mem[3]  <= enc_i(6'h08, 0, 3, 16'd1);
    mem[4]  <= enc_i(6'h08, 0, 4, 16'd2);
    mem[5]  <= enc_i(6'h05, 1, 2, 16'd4);
    mem[6]  <= enc_i(6'h08, 0, 5, 16'd3);
    mem[7]  <= enc_i(6'h08, 0, 0, 16'd7);
    mem[8]  <= 32'hFC00_0000;
    mem[9]  <= enc_j(26'd12);
    mem[10] <= enc_i(6'h08, 0, 6, 16'd4);
    mem[11] <= enc_i(6'h08, 0, 6, 16'd5);
    mem[12] <= enc_i(6'h08, 0, 7, 16'd9);
    mem[13] <= enc_j(26'd13);
    mem[512] <= x;
    mem[513] <= y;
    run(32'd52, cyc);
    chk("R7", "branch program cycles", 32'(cyc), eq ? 32'd34 : 32'd38);
    rd_reg(3, v); chk("R7", "beq skip r3", v, eq ? 32'd0 : 32'd1);
    rd_reg(4, v); chk("R7", "beq skip r4", v, eq ? 32'd0 : 32'd2);
    rd_reg(5, v); chk("R7", "bne skip r5", v, eq ? 32'd3 : 32'd0);
    rd_reg(0, v); chk("R9", "r0 after write", v, 32'd0);
    rd_reg(6, v); chk("R8", "jump skipped r6", v, 32'd0);
    rd_reg(7, v); chk("R8", "jump landed r7", v, 32'd9);
    rd_reg(20, v); chk("R10", "unknown op no write", v, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        alu_case(val(i), val(j), 16'(i * 16'h2345 + j * 16'h1111), (i * 5 + j * 3) % 32);
      end
    end
    branch_case(32'd5, 32'd5);
    branch_case(32'd5, 32'd6);
    branch_case(32'h8000_0000, 32'h8000_0000);
    branch_case(32'h0, 32'hFFFF_FFFF);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule